// File: doc/BRIEF.md
# Far-end fault indication generator

This block sits on the transmit side of a 100 Mbps fiber PHY, one line-code bit per clock. When the link is in fault, it stops forwarding the transmit code stream from the upstream data path. In its place it sends a fixed fault pattern. Each pattern is `ONES_LEN` one-bits followed by a single zero-bit. Once it starts, the pattern is sent at least `MIN_REPS` complete times back to back. The defaults are 84 ones and 3 repetitions, so one pattern lasts 85 bit times. When there is no fault, the upstream stream passes straight through to the output.

Fault code is sent only when four conditions hold at once:

- fiber mode is selected;
- fault signalling is enabled;
- loopback is off;
- a local fault exists, meaning signal detect reports no signal or the receive PLL has not locked.

The five condition inputs are asynchronous. They pass through a two-flop synchronizer before any decision uses them. A state machine with three states, `ST_PASS`, `ST_MIN` and `ST_HOLD`, controls the output:

- `ST_PASS` goes to `ST_MIN` on the first clock in which the synchronized qualification is true.
- `ST_MIN` sends the mandatory repetitions. On the zero bit of the last mandatory pattern, it goes to `ST_HOLD` if the fault is still qualified, and to `ST_PASS` otherwise.
- `ST_HOLD` repeats the pattern with no gap. It returns to `ST_PASS` on the zero bit of the first pattern that ends while the fault is no longer qualified.

Condition changes therefore act only at pattern boundaries. A status output is high in both fault states.

Top module: `fefi_gen`

## Requirements
- R1: The synchronous active-high reset puts the block in pass-through: `fault_active_o` is 0 and `tx_code_o` equals `tx_code_i` from the first clock after reset.
- R2: Every fault pattern is `ONES_LEN` consecutive 1 bits followed by exactly one 0 bit. Counting from 0 at the first fault bit, the 0 falls at positions where the position modulo `ONES_LEN+1` equals `ONES_LEN`.
- R3: No fault code is sent unless fiber mode (`fiber_mode_i`=1) is selected and loopback (`loopback_i`=1 means active) is off.
- R4: A local fault exists exactly when `sig_det_i`=0 (no signal) or `pll_lock_i`=0 (not locked). With both at 1, no fault code is sent.
- R5: While fault code is being sent, `tx_code_o` does not depend on `tx_code_i`.
- R6: With `fault_en_i`=0, the block never sends fault code and passes `tx_code_i` through, even when a local fault exists.
- R7: Once fault code starts, at least `MIN_REPS` complete patterns are sent, even if qualification lasts only a single clock.
- R8: While qualification persists beyond the mandatory repetitions, the pattern repeats with no gap. After qualification drops, the block returns to pass-through only on the clock that follows a pattern's 0 bit.
- R9: The condition inputs pass through two synchronizer flops. A qualifying change driven before clock edge n shows on `fault_active_o` after edge n+2 and not earlier. A drop in qualification ends the code only at the first pattern boundary that the synchronized value reaches.
- R10: `fault_active_o` is 1 exactly on the clocks in which the output carries fault code, and `tx_code_o` equals `tx_code_i` whenever it is 0.
- R11: A reset applied during fault code returns the block to pass-through on the next clock. A later fault starts a fresh pattern at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one code bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fiber_mode_i | input | 1 | 1 when the port runs in fiber mode (asynchronous) |
| fault_en_i | input | 1 | 1 enables far-end fault signalling (asynchronous) |
| sig_det_i | input | 1 | 1 when the optical receiver detects signal (asynchronous) |
| pll_lock_i | input | 1 | 1 when the receive PLL is locked (asynchronous) |
| loopback_i | input | 1 | 1 when loopback is active (asynchronous) |
| tx_code_i | input | 1 | Upstream transmit code bit |
| tx_code_o | output | 1 | Transmit code bit toward the line encoder |
| fault_active_o | output | 1 | 1 while fault code is being sent |

## Verification
The bench builds the block with `ONES_LEN`=5 and `MIN_REPS`=3, so a pattern is 6 bits and the mandatory run is 18 bits. It sweeps all 32 combinations of the five condition inputs, computes the expected qualification in the bench, and checks every output bit against the position-modulo-6 rule. The short pattern brings several cases into reach within a few dozen cycles: the one-clock qualification pulse, drops landing on different bit positions of a sustained run, and a reset in the middle of a pattern.

// File: rtl/fefi_pkg.sv
package fefi_pkg;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_MIN  = 2'd1,
        ST_HOLD = 2'd2
    } fefi_state_t;

    // Bit positions of the condition vector fed through the synchronizer.
    localparam int unsigned COND_FIBER = 0;
    localparam int unsigned COND_EN    = 1;
    localparam int unsigned COND_SD    = 2;
    localparam int unsigned COND_LOCK  = 3;
    localparam int unsigned COND_LOOP  = 4;
    localparam int unsigned COND_W     = 5;

endpackage

// File: rtl/fefi_sync.sv
module fefi_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/fefi_qualify.sv
module fefi_qualify
    import fefi_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    output logic              qual_o
);

    logic local_fault;

    always_comb begin
        local_fault = !cond_i[COND_SD] || !cond_i[COND_LOCK];
        qual_o      = cond_i[COND_FIBER] && cond_i[COND_EN]
                      && !cond_i[COND_LOOP] && local_fault;
    end

endmodule

// File: rtl/fefi_pattern.sv
module fefi_pattern #(
    parameter int unsigned ONES_LEN = 84,
    parameter int unsigned MIN_REPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic code_bit_o,
    output logic pat_end_o,
    output logic min_done_o
);

    localparam int unsigned BW = $clog2(ONES_LEN + 1);
    localparam int unsigned RW = $clog2(MIN_REPS + 1);
    localparam logic [BW-1:0] LAST_POS = BW'(ONES_LEN);
    localparam logic [RW-1:0] LAST_REP = RW'(MIN_REPS - 1);

    logic [BW-1:0] bit_cnt;
    logic [RW-1:0] rep_cnt;

    always_comb begin
        pat_end_o  = (bit_cnt == LAST_POS);
        code_bit_o = !pat_end_o;
        min_done_o = pat_end_o && (rep_cnt == LAST_REP);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            bit_cnt <= '0;
            rep_cnt <= '0;
        end else if (pat_end_o) begin
            bit_cnt <= '0;
            if (rep_cnt != LAST_REP) rep_cnt <= rep_cnt + 1'b1;
        end else begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fefi_gen.sv
module fefi_gen
    import fefi_pkg::*;
#(
    parameter int unsigned ONES_LEN    = 84,
    parameter int unsigned MIN_REPS    = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fiber_mode_i,
    input  logic fault_en_i,
    input  logic sig_det_i,
    input  logic pll_lock_i,
    input  logic loopback_i,
    input  logic tx_code_i,
    output logic tx_code_o,
    output logic fault_active_o
);

    logic [COND_W-1:0] cond_raw;
    logic [COND_W-1:0] cond_sync;
    logic              qual;
    logic              run;
    logic              code_bit;
    logic              pat_end;
    logic              min_done;
    fefi_state_t       state_q;
    fefi_state_t       state_d;

    always_comb begin
        cond_raw             = '0;
        cond_raw[COND_FIBER] = fiber_mode_i;
        cond_raw[COND_EN]    = fault_en_i;
        cond_raw[COND_SD]    = sig_det_i;
        cond_raw[COND_LOCK]  = pll_lock_i;
        cond_raw[COND_LOOP]  = loopback_i;
    end

    fefi_sync #(
        .WIDTH  (COND_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (cond_raw),
        .sync_o  (cond_sync)
    );

    fefi_qualify u_qual (
        .cond_i (cond_sync),
        .qual_o (qual)
    );

    fefi_pattern #(
        .ONES_LEN (ONES_LEN),
        .MIN_REPS (MIN_REPS)
    ) u_pat (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run),
        .code_bit_o (code_bit),
        .pat_end_o  (pat_end),
        .min_done_o (min_done)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PASS;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS: if (qual) state_d = ST_MIN;
            ST_MIN:  if (min_done) state_d = qual ? ST_HOLD : ST_PASS;
            ST_HOLD: if (pat_end && !qual) state_d = ST_PASS;
            default: state_d = ST_PASS;
        endcase
    end

    always_comb begin
        run            = 1'b0;
        fault_active_o = 1'b0;
        tx_code_o      = tx_code_i;
        unique case (state_q)
            ST_PASS: begin
                run       = 1'b0;
                tx_code_o = tx_code_i;
            end
            ST_MIN, ST_HOLD: begin
                run            = 1'b1;
                fault_active_o = 1'b1;
                tx_code_o      = code_bit;
            end
            default: begin
                run       = 1'b0;
                tx_code_o = tx_code_i;
            end
        endcase
    end

endmodule

// File: rtl/fefi_gen_checker.sv
module fefi_gen_checker #(
    parameter int unsigned ONES_LEN = 84,
    parameter int unsigned MIN_REPS = 3
) (
    input logic clk,
    input logic rst,
    input logic tx_code_i,
    input logic tx_code_o,
    input logic fault_active_o
);

    localparam int unsigned OW = $clog2(ONES_LEN + 1);
    localparam int unsigned ZW = $clog2(MIN_REPS + 1);

    logic [OW-1:0] ones_run;
    logic [ZW-1:0] zeros_seen;

    always_ff @(posedge clk) begin
        if (rst || !fault_active_o) begin
            ones_run   <= '0;
            zeros_seen <= '0;
        end else if (tx_code_o) begin
            ones_run <= ones_run + 1'b1;
        end else begin
            ones_run <= '0;
            if (zeros_seen != ZW'(MIN_REPS)) zeros_seen <= zeros_seen + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !fault_active_o);

    p_ones_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (fault_active_o && tx_code_o) |-> (ones_run < OW'(ONES_LEN)));

    p_zero_pos_r2: assert property (@(posedge clk) disable iff (rst)
        (fault_active_o && !tx_code_o) |-> (ones_run == OW'(ONES_LEN)));

    p_pass_through_r10: assert property (@(posedge clk) disable iff (rst)
        !fault_active_o |-> (tx_code_o == tx_code_i));

    p_min_reps_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(fault_active_o) && !$past(rst)) |-> (zeros_seen == ZW'(MIN_REPS)));

    p_exit_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(fault_active_o) && !$past(rst)) |-> !$past(tx_code_o));

    p_start_one_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_active_o) |-> tx_code_o);

endmodule

bind fefi_gen fefi_gen_checker #(
    .ONES_LEN (ONES_LEN),
    .MIN_REPS (MIN_REPS)
) u_fefi_chk (
    .clk            (clk),
    .rst            (rst),
    .tx_code_i      (tx_code_i),
    .tx_code_o      (tx_code_o),
    .fault_active_o (fault_active_o)
);

// File: tb/fefi_gen_bench.sv
module fefi_gen_bench;

    localparam int unsigned ONES = 5;
    localparam int unsigned REPS = 3;
    localparam int unsigned PLEN = ONES + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fm = 1'b0, en = 1'b0, sd = 1'b1, pl = 1'b1, lb = 1'b0;
    logic tx_i = 1'b0;
    logic tx_o, fa;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fefi_gen #(
        .ONES_LEN    (ONES),
        .MIN_REPS    (REPS),
        .SYNC_STAGES (2)
    ) u_fefi_gen (
        .clk            (clk),
        .rst            (rst),
        .fiber_mode_i   (fm),
        .fault_en_i     (en),
        .sig_det_i      (sd),
        .pll_lock_i     (pl),
        .loopback_i     (lb),
        .tx_code_i      (tx_i),
        .tx_code_o      (tx_o),
        .fault_active_o (fa)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fm = 1'b0; en = 1'b0; sd = 1'b1; pl = 1'b1; lb = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    // Pattern bit expected at fault position k (R2).
    function automatic logic pat_bit(input int k);
        return (k % PLEN) != ONES;
    endfunction

    // Checks one fault or pass-through sample at index k.
    task automatic sample(input int k, input logic exp_fault, input string req);
        tick();
        tx_i = logic'((k * 7 + 3) % 5 > 1);
        #1;
        chk(req, fa, exp_fault);
        if (exp_fault) chk("R2/R5 fault bit", tx_o, pat_bit(k));
        else           chk("R10 pass-through", tx_o, tx_i);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        tx_i = 1'b1; #1;
        chk("R1 reset status", fa, 1'b0);
        chk("R1 reset pass", tx_o, 1'b1);
        tick(); tx_i = 1'b0; #1;
        chk("R1 reset pass", tx_o, 1'b0);

        // Sweep all condition combinations (R3, R4, R6, R9, R8)
        for (int c = 0; c < 32; c++) begin
            logic expq;
            string req;
            do_reset();
            fm = c[0]; en = c[1]; sd = c[2]; pl = c[3]; lb = c[4];
            expq = c[0] && c[1] && !c[4] && (!c[2] || !c[3]);
            if (!c[1])              req = "R6 enable clear";
            else if (!c[0] || c[4]) req = "R3 qualification";
            else                    req = "R4 fault present";
            tick(); tick(); #1;
            chk("R9 sync latency", fa, 1'b0);
            if (!expq) begin
                for (int k = 0; k < 12; k++) sample(k, 1'b0, req);
            end else begin
                for (int k = 0; k < 30; k++) begin
                    sample(k, k <= 23, "R8 sustained then boundary exit");
                    if (k == 20) begin sd = 1'b1; pl = 1'b1; end
                end
            end
        end

        // R7: a one-clock qualification pulse still yields the minimum repetitions
        do_reset();
        fm = 1'b1; en = 1'b1; sd = 1'b0; pl = 1'b1; lb = 1'b0;
        tick();
        sd = 1'b1;
        tick(); #1;
        chk("R9 sync latency", fa, 1'b0);
        for (int k = 0; k < 24; k++) sample(k, k < REPS * PLEN, "R7 minimum repetitions");

        // R9: drop lands one bit later, so exit moves to the next boundary
        do_reset();
        fm = 1'b1; en = 1'b1; sd = 1'b1; pl = 1'b0; lb = 1'b0;
        tick(); tick();
        for (int k = 0; k < 36; k++) begin
            sample(k, k <= 29, "R9 boundary-only exit");
            if (k == 22) pl = 1'b1;
        end

        // R11: reset in the middle of a pattern
        do_reset();
        fm = 1'b1; en = 1'b1; sd = 1'b0; pl = 1'b0; lb = 1'b0;
        tick(); tick();
        for (int k = 0; k < 9; k++) sample(k, 1'b1, "R11 before reset");
        tick();
        rst = 1'b1;
        tick(); #1;
        chk("R11 reset mid-fault", fa, 1'b0);
        rst = 1'b0;
        tick(); tick();
        for (int k = 0; k < 2 * PLEN; k++) sample(k, 1'b1, "R11 fresh pattern");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule